// File: doc/BRIEF.md
# Instrument science frame parser

The parser sits behind a serial byte receiver. It turns the reply that an instrument sends after each command into typed fields. Bytes arrive one per `rxValid` strobe. Once a command has been issued, the parser walks a fixed 124-byte frame, which has the following parts:

- a status byte, which yields a housekeeping address, a pulse-height address and a command-accepted flag;
- sixty 16-bit counters, each sent high byte first, each emitted with its index when its low byte lands;
- an overflow byte, latched unchanged;
- a housekeeping sample with its resolution flag;
- a 4-bit threshold.

After the frame, the parser runs in an open-ended event mode. Every further byte is reported as a pulse-height event with a 7-bit value and a resolution flag. This continues until the next command restarts the frame.

A receive timeout or parity error, signalled by the byte receiver, aborts the frame or the event stream. It raises a sticky error flag and parks the parser until a new command arrives. Every output is registered and changes on the clock edge that accepts the byte.

Top module: `sciFrameParser`

## Requirements
- R1: After reset all outputs are zero and the parser waits for a command. Bytes and receiver errors seen before the first command change no output.
- R2: On the clock edge that accepts frame byte 1, `hkAddr` takes bits 2:0, `phaAddr` takes bits 5:4 (0 means analysis off) and `cmdOk` takes bit 3. `statusValid` pulses for that one cycle.
- R3: Frame bytes 2 to 121 form 60 counters, high byte first. On the edge that accepts a counter's low byte, `cntValid` pulses, `cntIndex` gives 0 to 59 in arrival order and `cntValue` = {high byte, low byte}.
- R4: Frame byte 122 is copied unchanged to `ovfFlags`.
- R5: Frame byte 123 sets `hkValue` to bits 6:0 and `hkCoarse` to bit 7 (1 = coarse, 0 = fine).
- R6: Frame byte 124 sets `threshold` to bits 3:0. Bits 7:4 have no effect on any output.
- R7: `frameDone` is high for exactly one cycle, starting one cycle after `threshold` is updated.
- R8: After byte 124, each accepted byte pulses `evtValid` with `evtValue` = bits 6:0 and `evtCoarse` = bit 7, for any number of bytes.
- R9: `cmdIssued` lets a byte accepted in the same cycle complete in the current mode. The next byte is then treated as byte 1 of a new frame, and `errFlag` clears.
- R10: `rxErr` during a frame or event stream drops that cycle's byte and sets `errFlag`. Further bytes are ignored until `cmdIssued`. If `rxErr` and `cmdIssued` coincide, the command wins and the flag stays clear.
- R11: Cycles without `rxValid` do not advance the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| rxErr | input | 1 | Receiver timeout or parity error |
| cmdIssued | input | 1 | New command has been sent |
| statusValid | output | 1 | Status byte decoded this cycle |
| hkAddr | output | 3 | Housekeeping channel address |
| phaAddr | output | 2 | Pulse-height analysis address |
| cmdOk | output | 1 | Previous command accepted |
| cntValid | output | 1 | Counter value present |
| cntIndex | output | 6 | Counter number 0..59 |
| cntValue | output | 16 | Counter value |
| ovfFlags | output | 8 | Overflow byte |
| hkValue | output | 7 | Housekeeping sample |
| hkCoarse | output | 1 | Housekeeping resolution flag |
| threshold | output | 4 | Threshold level |
| frameDone | output | 1 | Frame complete pulse |
| evtValid | output | 1 | Pulse-height event present |
| evtValue | output | 7 | Event value |
| evtCoarse | output | 1 | Event resolution flag |
| errFlag | output | 1 | Frame aborted by receiver error |

## Verification
A wrong byte position inside the frame shows up within one byte. It appears as a counter index or value off by one, or as a field landing in the wrong output. A mode error shows up on the first byte after byte 124, as a missing `evtValid` or a spurious `cntValid`. The same applies to a command or error arriving mid-frame, where the misbehaviour appears on the following byte. Because the reference model is compared on every clock, each such fault is reported in the cycle it first reaches a port.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  parameter int BYTE_W    = 8;
  parameter int NUM_CNT   = 60;
  parameter int CNT_W     = 2 * BYTE_W;
  parameter int HKA_W     = 3;
  parameter int PHA_LSB   = 4;
  parameter int PHA_W     = 2;
  parameter int OK_BIT    = 3;
  parameter int SAMPLE_W  = 7;
  parameter int THR_W     = 4;
  localparam int FRAME_BYTES = 2 * NUM_CNT + 4;
  localparam int IDX_W    = $clog2(FRAME_BYTES);
  localparam int CIDX_W   = $clog2(NUM_CNT);
  localparam int LAST_CNT = 2 * NUM_CNT;
  localparam int OVF_POS  = LAST_CNT + 1;
  localparam int HK_POS   = LAST_CNT + 2;
  localparam int THR_POS  = LAST_CNT + 3;

  typedef enum logic [1:0] {ST_WAIT, ST_FRAME, ST_EVENT} sfpState_t;

  typedef struct packed {
    logic              stStatus;
    logic              stCntHi;
    logic              stCntLo;
    logic              stOvf;
    logic              stHk;
    logic              stThr;
    logic              stEvt;
    logic [CIDX_W-1:0] cntIdx;
  } sfpStrobe_t;
endpackage

// File: rtl/sfpCtrl.sv
module sfpCtrl
  import sfp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxErr,
  input  logic       cmdIssued,
  output sfpStrobe_t strobe,
  output logic       errFlag
);
  sfpState_t         state;
  logic [IDX_W-1:0]  byteIdx;
  logic              abortByte;
  logic              frameByte;
  logic              inCnt;

  // A receiver error only matters while a frame or event stream is open.
  assign abortByte = rxErr && (state != ST_WAIT);
  assign frameByte = (state == ST_FRAME) && rxValid && !abortByte;
  assign inCnt     = (byteIdx >= IDX_W'(1)) && (byteIdx <= IDX_W'(LAST_CNT));

  always_comb begin
    strobe          = '0;
    strobe.stStatus = frameByte && (byteIdx == '0);
    strobe.stCntHi  = frameByte && inCnt && byteIdx[0];
    strobe.stCntLo  = frameByte && inCnt && !byteIdx[0];
    strobe.stOvf    = frameByte && (byteIdx == IDX_W'(OVF_POS));
    strobe.stHk     = frameByte && (byteIdx == IDX_W'(HK_POS));
    strobe.stThr    = frameByte && (byteIdx == IDX_W'(THR_POS));
    strobe.stEvt    = (state == ST_EVENT) && rxValid && !abortByte;
    strobe.cntIdx   = CIDX_W'((byteIdx - IDX_W'(2)) >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      byteIdx <= '0;
      errFlag <= 1'b0;
    end else if (cmdIssued) begin
      state   <= ST_FRAME;
      byteIdx <= '0;
      errFlag <= 1'b0;
    end else if (abortByte) begin
      state   <= ST_WAIT;
      byteIdx <= '0;
      errFlag <= 1'b1;
    end else if (frameByte) begin
      byteIdx <= byteIdx + IDX_W'(1);
      if (byteIdx == IDX_W'(THR_POS)) state <= ST_EVENT;
    end
  end

  // R10: an aborted stream leaves the parser waiting for a command
  assert_err_parks_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (state == ST_WAIT));
  // R10: the error flag rises only after a receiver error
  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(rxErr));
  // R3: at most one field is written per accepted byte
  assert_one_field_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stStatus, strobe.stCntHi, strobe.stCntLo, strobe.stOvf,
              strobe.stHk, strobe.stThr, strobe.stEvt}));
endmodule

// File: rtl/sfpDatapath.sv
module sfpDatapath
  import sfp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  sfpStrobe_t          strobe,
  input  logic [BYTE_W-1:0]   rxByte,
  output logic                statusValid,
  output logic [HKA_W-1:0]    hkAddr,
  output logic [PHA_W-1:0]    phaAddr,
  output logic                cmdOk,
  output logic                cntValid,
  output logic [CIDX_W-1:0]   cntIndex,
  output logic [CNT_W-1:0]    cntValue,
  output logic [BYTE_W-1:0]   ovfFlags,
  output logic [SAMPLE_W-1:0] hkValue,
  output logic                hkCoarse,
  output logic [THR_W-1:0]    threshold,
  output logic                frameDone,
  output logic                evtValid,
  output logic [SAMPLE_W-1:0] evtValue,
  output logic                evtCoarse
);
  logic [BYTE_W-1:0] msbHold;
  logic              thrSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusValid <= 1'b0;
      hkAddr      <= '0;
      phaAddr     <= '0;
      cmdOk       <= 1'b0;
      cntValid    <= 1'b0;
      cntIndex    <= '0;
      cntValue    <= '0;
      msbHold     <= '0;
      ovfFlags    <= '0;
      hkValue     <= '0;
      hkCoarse    <= 1'b0;
      threshold   <= '0;
      thrSeen     <= 1'b0;
      frameDone   <= 1'b0;
      evtValid    <= 1'b0;
      evtValue    <= '0;
      evtCoarse   <= 1'b0;
    end else begin
      statusValid <= strobe.stStatus;
      cntValid    <= strobe.stCntLo;
      evtValid    <= strobe.stEvt;
      thrSeen     <= strobe.stThr;
      frameDone   <= thrSeen;
      if (strobe.stStatus) begin
        hkAddr  <= rxByte[HKA_W-1:0];
        phaAddr <= rxByte[PHA_LSB +: PHA_W];
        cmdOk   <= rxByte[OK_BIT];
      end
      if (strobe.stCntHi) msbHold <= rxByte;
      if (strobe.stCntLo) begin
        cntIndex <= strobe.cntIdx;
        cntValue <= {msbHold, rxByte};
      end
      if (strobe.stOvf) ovfFlags <= rxByte;
      if (strobe.stHk) begin
        hkValue  <= rxByte[SAMPLE_W-1:0];
        hkCoarse <= rxByte[BYTE_W-1];
      end
      if (strobe.stThr) threshold <= rxByte[THR_W-1:0];
      if (strobe.stEvt) begin
        evtValue  <= rxByte[SAMPLE_W-1:0];
        evtCoarse <= rxByte[BYTE_W-1];
      end
    end
  end

  // R3: counter index stays inside the counter bank
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntValid |-> (cntIndex < CIDX_W'(NUM_CNT)));
  // R7: frame completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R8: event reports and counter reports never share a cycle
  assert_evt_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> !(cntValid || statusValid));
endmodule

// File: rtl/sciFrameParser.sv
module sciFrameParser
  import sfp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic                rxErr,
  input  logic                cmdIssued,
  output logic                statusValid,
  output logic [HKA_W-1:0]    hkAddr,
  output logic [PHA_W-1:0]    phaAddr,
  output logic                cmdOk,
  output logic                cntValid,
  output logic [CIDX_W-1:0]   cntIndex,
  output logic [CNT_W-1:0]    cntValue,
  output logic [BYTE_W-1:0]   ovfFlags,
  output logic [SAMPLE_W-1:0] hkValue,
  output logic                hkCoarse,
  output logic [THR_W-1:0]    threshold,
  output logic                frameDone,
  output logic                evtValid,
  output logic [SAMPLE_W-1:0] evtValue,
  output logic                evtCoarse,
  output logic                errFlag
);
  sfpStrobe_t strobe;

  sfpCtrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxErr(rxErr),
    .cmdIssued(cmdIssued), .strobe(strobe), .errFlag(errFlag)
  );

  sfpDatapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .statusValid(statusValid), .hkAddr(hkAddr), .phaAddr(phaAddr),
    .cmdOk(cmdOk), .cntValid(cntValid), .cntIndex(cntIndex),
    .cntValue(cntValue), .ovfFlags(ovfFlags), .hkValue(hkValue),
    .hkCoarse(hkCoarse), .threshold(threshold), .frameDone(frameDone),
    .evtValid(evtValid), .evtValue(evtValue), .evtCoarse(evtCoarse)
  );
endmodule

// File: tb/sciFrameParser_test.sv
module sciFrameParser_test;
  logic clk = 1'b0;
  logic rstN;
  logic rxValid = 1'b0, rxErr = 1'b0, cmdIssued = 1'b0;
  logic [7:0] rxByte = '0;
  logic statusValid, cmdOk, cntValid, hkCoarse, frameDone, evtValid, evtCoarse, errFlag;
  logic [2:0] hkAddr;
  logic [1:0] phaAddr;
  logic [5:0] cntIndex;
  logic [15:0] cntValue;
  logic [7:0] ovfFlags;
  logic [6:0] hkValue, evtValue;
  logic [3:0] threshold;

  sciFrameParser uut (.*);

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;
  bit started = 0, ended = 0;
  string phase = "R1";

  // behavioural reference
  int mode = 0, idx = 0, doneArm = 0;
  int msb = 0;
  int eStatV = 0, eHka = 0, ePha = 0, eOk = 0, eCntV = 0, eCntI = 0, eCntVal = 0;
  int eOvf = 0, eHk = 0, eHkC = 0, eThr = 0, eDone = 0, eEvtV = 0, eEvt = 0, eEvtC = 0, eErr = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mode = 0; idx = 0; doneArm = 0; msb = 0;
      eStatV = 0; eHka = 0; ePha = 0; eOk = 0; eCntV = 0; eCntI = 0; eCntVal = 0;
      eOvf = 0; eHk = 0; eHkC = 0; eThr = 0; eDone = 0; eEvtV = 0; eEvt = 0; eEvtC = 0; eErr = 0;
    end else begin
      int b;
      b = int'(rxByte);
      eStatV = 0; eCntV = 0; eEvtV = 0;
      eDone = doneArm; doneArm = 0;
      if (mode != 0 && rxErr) begin
        if (!cmdIssued) begin eErr = 1; mode = 0; end
      end else if (rxValid && mode == 1) begin
        if (idx == 0) begin
          eStatV = 1; eHka = b % 8; ePha = (b / 16) % 4; eOk = (b / 8) % 2;
        end else if (idx <= 120) begin
          if (idx % 2 == 1) msb = b;
          else begin eCntV = 1; eCntI = idx / 2 - 1; eCntVal = msb * 256 + b; end
        end else if (idx == 121) eOvf = b;
        else if (idx == 122) begin eHk = b % 128; eHkC = b / 128; end
        else begin eThr = b % 16; doneArm = 1; mode = 2; end
        idx++;
      end else if (rxValid && mode == 2) begin
        eEvtV = 1; eEvt = b % 128; eEvtC = b / 128;
      end
      if (cmdIssued) begin mode = 1; idx = 0; eErr = 0; end
    end
  end

  task automatic chk(string req, string nm, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [phase %s] %s: actual %0h expected %0h", req, phase, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !ended) begin
    chk("R2", "statusValid", int'(statusValid), eStatV);
    chk("R2", "hkAddr", int'(hkAddr), eHka);
    chk("R2", "phaAddr", int'(phaAddr), ePha);
    chk("R2", "cmdOk", int'(cmdOk), eOk);
    chk("R3", "cntValid", int'(cntValid), eCntV);
    chk("R3", "cntIndex", int'(cntIndex), eCntI);
    chk("R3", "cntValue", int'(cntValue), eCntVal);
    chk("R4", "ovfFlags", int'(ovfFlags), eOvf);
    chk("R5", "hkValue", int'(hkValue), eHk);
    chk("R5", "hkCoarse", int'(hkCoarse), eHkC);
    chk("R6", "threshold", int'(threshold), eThr);
    chk("R7", "frameDone", int'(frameDone), eDone);
    chk("R8", "evtValid", int'(evtValid), eEvtV);
    chk("R8", "evtValue", int'(evtValue), eEvt);
    chk("R8", "evtCoarse", int'(evtCoarse), eEvtC);
    chk("R10", "errFlag", int'(errFlag), eErr);
  end

  task automatic step(bit v, logic [7:0] b, bit c, bit e);
    @(negedge clk);
    rxValid = v; rxByte = b; cmdIssued = c; rxErr = e;
  endtask

  task automatic sendFrame(logic [7:0] stat, logic [7:0] thr, int seed, int count);
    for (int i = 0; i < count; i++) begin
      logic [7:0] b;
      b = (i == 0) ? stat : (i == 123) ? thr : 8'(i * 37 + seed * 11 + 5);
      step(1'b1, b, 1'b0, 1'b0);
      if (i % 7 == 3) step(1'b0, 8'hEE, 1'b0, 1'b0);  // R11: gap cycle
    end
    step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    started = 1;
    @(negedge clk);
    // R1: reset values
    chk("R1", "reset statusValid", int'(statusValid), 0);
    chk("R1", "reset errFlag", int'(errFlag), 0);
    rstN = 1'b1;
    // R1: traffic before any command is ignored
    step(1, 8'h3F, 0, 0); step(1, 8'hFF, 0, 1); step(1, 8'h81, 0, 0);
    step(0, 8'h00, 0, 0);
    phase = "R9";
    step(0, 8'h00, 1, 0);
    phase = "R2-frame1";
    sendFrame(8'hBD, 8'hF6, 1, 124);   // R6: upper nibble of F6 ignored
    phase = "R8";
    step(1, 8'h80, 0, 0); step(1, 8'h7F, 0, 0); step(0, 8'h00, 0, 0);
    step(1, 8'h15, 0, 0); step(1, 8'hAA, 0, 0);
    phase = "R9";
    step(1, 8'hC3, 1, 0);              // event completes, then restart
    phase = "R10";
    sendFrame(8'h42, 8'h00, 2, 40);
    step(1, 8'h99, 0, 1);              // abort, byte dropped
    step(1, 8'h11, 0, 0); step(1, 8'h22, 0, 0); step(0, 8'h00, 0, 0);
    step(1, 8'h33, 1, 1);              // command wins over error
    phase = "R3-frame3";
    sendFrame(8'h42, 8'h09, 3, 124);
    step(1, 8'hFE, 0, 0); step(1, 8'h01, 0, 0);
    phase = "R9-midframe";
    step(0, 8'h00, 1, 0);
    sendFrame(8'h7A, 8'h00, 4, 11);
    step(1, 8'h5C, 1, 0);              // byte completes in frame, restart
    sendFrame(8'h05, 8'h3C, 5, 124);
    repeat (5) step(0, 8'h00, 0, 0);
    @(negedge clk);
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      ended = 1; fails++;
      $display("FAIL watchdog [phase %s]: actual timeout expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule